// File: doc/BRIEF.md
# Processor Mode and Width Controller

This block is the mode-control slice of a CPU that can run in three nested modes: 32-bit native, 16-bit emulation and 8-bit emulation. Two stacked emulation flags, here called `emu_hi` (the upper level) and `emu_lo` (the lower level), hold the current mode. Reset places the core in 8-bit emulation.

The only way to change the mode is the two-byte flag-exchange instruction. It swaps `emu_hi` with the overflow bit and `emu_lo` with the carry bit in a single step. The status register lives outside this block. It supplies the current overflow and carry values, and it takes back the old emulation flags through `v_new` and `c_new` when `xchg_done` pulses.

From the mode and the M and X status bits, the block reports the accumulator and index widths to the datapath. It also reports the 24-bit interrupt vector address for the selected interrupt source. A pulse tells the register file to clear the upper bits of X and Y whenever an exchange narrows the index registers.

Top module: `cpu_mode_ctrl`

## Requirements
- R1: After reset `emu_hi`=1 and `emu_lo`=1, `mode`=2 (8-bit emulation), `xchg_done`=0, `idx_clear`=0, `v_new`=0 and `c_new`=0.
- R2: The exchange is triggered when a valid byte 0x42 is followed by the next valid byte equal to parameter `XCHG_OP` (default 0xFB). The flags change at the clock edge that accepts the second byte, and `xchg_done` is 1 for the cycle that follows. A repeated 0x42 keeps the sequence armed.
- R3: A second byte that arrives without the prefix, or a prefix followed by any other byte, leaves `emu_hi` and `emu_lo` unchanged and gives no `xchg_done`. The flags change at no other time.
- R4: On an exchange `emu_hi` takes `v_in` and `emu_lo` takes `c_in` in the same cycle. `v_new` and `c_new` take the old `emu_hi` and `emu_lo`.
- R5: `mode` encodes {emu_hi, emu_lo} as follows: 00 gives 0 (32-bit native), 10 gives 1 (16-bit emulation), 11 gives 2 (8-bit emulation), and 01 gives 3 (32-bit native with a narrowed accumulator).
- R6: `acc_w` (0=8, 1=16, 2=32 bits) is 0 when M=1, 1 when M=0 and `emu_lo`=1, and 2 when M=0 and `emu_lo`=0.
- R7: `idx_w` (same encoding) is 0 when X=1. When X=0 it is 2 if `emu_hi`=0 and 1 if `emu_hi`=1.
- R8: The `vec_src` codes are 0 COP, 1 BRK, 2 NMI, 3 IRQ and 4 reset; codes 5 to 7 act as IRQ. The vector bank is 0xFFD_ when `emu_hi`=0, 0xFFE_ in 16-bit emulation and 0xFFF_ in 8-bit emulation. The low nibble is 4 for COP, 6 for BRK, A for NMI and E for IRQ, except that BRK uses E in 8-bit emulation.
- R9: The reset source gives 0x00FFFC in every mode. `vec_addr` is 24 bits wide and its upper byte is always 0.
- R10: `idx_clear` pulses together with `xchg_done` exactly when the exchange raises `emu_hi` from 0 to 1 while X=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A decoded instruction byte is presented |
| op_byte | input | 8 | Instruction byte value |
| v_in | input | 1 | Current overflow status bit |
| c_in | input | 1 | Current carry status bit |
| m_flag | input | 1 | Accumulator-width status bit |
| x_flag | input | 1 | Index-width status bit |
| vec_src | input | 3 | Interrupt source code |
| emu_hi | output | 1 | Upper emulation flag |
| emu_lo | output | 1 | Lower emulation flag |
| v_new | output | 1 | Overflow value returned by the last exchange |
| c_new | output | 1 | Carry value returned by the last exchange |
| xchg_done | output | 1 | Exchange completed; load v_new and c_new |
| idx_clear | output | 1 | Clear the upper bits of X and Y |
| mode | output | 2 | Decoded operating mode |
| acc_w | output | 2 | Accumulator width code |
| idx_w | output | 2 | Index width code |
| vec_addr | output | 24 | Interrupt vector address |

## Verification
A table of exchanges walks the flags through all four {emu_hi, emu_lo} combinations. Each row also sets a different M and X pair and a different interrupt source. This separates width rules that depend on the lower flag from those that depend on the upper flag. It also distinguishes the three vector banks and the BRK alias in 8-bit emulation. Because consecutive rows return the previous flags through `v_new` and `c_new`, a swapped or crossed exchange is detected, and the transitions between rows show whether `idx_clear` fires only on a rise of the upper flag with X=0. Directed sequences then confirm that a second byte without its prefix, or a prefix followed by another byte, leaves the flags alone, that a doubled prefix still arms the exchange, and that the reset vector is the same in every mode.

// File: rtl/cpu_mode_ctrl.sv
module cpu_mode_ctrl #(
  parameter logic [7:0] PFX_OP  = 8'h42,
  parameter logic [7:0] XCHG_OP = 8'hFB
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [7:0]  op_byte,
  input  logic        v_in,
  input  logic        c_in,
  input  logic        m_flag,
  input  logic        x_flag,
  input  logic [2:0]  vec_src,
  output logic        emu_hi,
  output logic        emu_lo,
  output logic        v_new,
  output logic        c_new,
  output logic        xchg_done,
  output logic        idx_clear,
  output logic [1:0]  mode,
  output logic [1:0]  acc_w,
  output logic [1:0]  idx_w,
  output logic [23:0] vec_addr
);
  localparam logic [1:0] W8 = 2'd0, W16 = 2'd1, W32 = 2'd2;

  logic armed;
  logic hit;
  logic [3:0] bank, slot;

  assign hit = op_valid && armed && (op_byte == XCHG_OP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      emu_hi    <= 1'b1;
      emu_lo    <= 1'b1;
      v_new     <= 1'b0;
      c_new     <= 1'b0;
      xchg_done <= 1'b0;
      idx_clear <= 1'b0;
    end else begin
      xchg_done <= hit;
      idx_clear <= hit && !emu_hi && v_in && !x_flag;
      if (op_valid) armed <= (op_byte == PFX_OP);
      if (hit) begin
        emu_hi <= v_in;
        emu_lo <= c_in;
        v_new  <= emu_hi;
        c_new  <= emu_lo;
      end
    end
  end

  always_comb begin
    case ({emu_hi, emu_lo})
      2'b00:   mode = 2'd0;
      2'b10:   mode = 2'd1;
      2'b11:   mode = 2'd2;
      default: mode = 2'd3;
    endcase
  end

  assign acc_w = m_flag ? W8 : (emu_lo ? W16 : W32);
  assign idx_w = x_flag ? W8 : (emu_hi ? W16 : W32);

  assign bank = !emu_hi ? 4'hD : (emu_lo ? 4'hF : 4'hE);

  always_comb begin
    case (vec_src)
      3'd0:    slot = 4'h4;
      3'd1:    slot = (emu_hi && emu_lo) ? 4'hE : 4'h6;
      3'd2:    slot = 4'hA;
      3'd4:    slot = 4'hC;
      default: slot = 4'hE;
    endcase
  end

  assign vec_addr = (vec_src == 3'd4) ? 24'h00FFFC : {12'h00F, 4'hF, bank, slot};
endmodule

module cpu_mode_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        v_in,
  input logic        c_in,
  input logic        m_flag,
  input logic        x_flag,
  input logic [2:0]  vec_src,
  input logic        emu_hi,
  input logic        emu_lo,
  input logic        v_new,
  input logic        c_new,
  input logic        xchg_done,
  input logic        idx_clear,
  input logic [1:0]  acc_w,
  input logic [23:0] vec_addr
);
  // R4
  swap_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_done |-> (emu_hi == $past(v_in)) && (emu_lo == $past(c_in)) &&
                  (v_new == $past(emu_hi)) && (c_new == $past(emu_lo)));

  // R3
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xchg_done |-> $stable(emu_hi) && $stable(emu_lo));

  // R10
  idx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_clear |-> xchg_done && emu_hi && !$past(emu_hi) && !$past(x_flag));

  // R6
  acc_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_flag |-> acc_w == 2'd0);

  // R9
  reset_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_src == 3'd4) |-> vec_addr == 24'h00FFFC);

  // R8
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_addr[23:8] == 16'h00FF) && (vec_addr[7:6] == 2'b11) && (vec_addr[4:0] != 5'd0) && !vec_addr[0]);
endmodule

bind cpu_mode_ctrl cpu_mode_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .v_in(v_in), .c_in(c_in), .m_flag(m_flag), .x_flag(x_flag),
  .vec_src(vec_src), .emu_hi(emu_hi), .emu_lo(emu_lo), .v_new(v_new), .c_new(c_new),
  .xchg_done(xchg_done), .idx_clear(idx_clear), .acc_w(acc_w), .vec_addr(vec_addr)
);

// File: tb/cpu_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module cpu_mode_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [7:0] op_byte = 8'h00;
  logic v_in = 1'b0, c_in = 1'b0, m_flag = 1'b0, x_flag = 1'b0;
  logic [2:0] vec_src = 3'd0;
  logic emu_hi, emu_lo, v_new, c_new, xchg_done, idx_clear;
  logic [1:0] mode, acc_w, idx_w;
  logic [23:0] vec_addr;

  int errors = 0;
  int checks = 0;
  logic m_hi = 1'b1, m_lo = 1'b1;

  always #10 clk = ~clk;

  cpu_mode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
    .v_in(v_in), .c_in(c_in), .m_flag(m_flag), .x_flag(x_flag), .vec_src(vec_src),
    .emu_hi(emu_hi), .emu_lo(emu_lo), .v_new(v_new), .c_new(c_new),
    .xchg_done(xchg_done), .idx_clear(idx_clear), .mode(mode),
    .acc_w(acc_w), .idx_w(idx_w), .vec_addr(vec_addr)
  );

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {v, c, m, x, src[2:0], acc[1:0], idx[1:0], mode[1:0], vec[15:0]}
  localparam int N = 12;
  localparam logic [28:0] TBL [N] = '{
    {1'b0,1'b0,1'b0,1'b0,3'd3,2'd2,2'd2,2'd0,16'hFFDE},
    {1'b0,1'b0,1'b1,1'b1,3'd0,2'd0,2'd0,2'd0,16'hFFD4},
    {1'b1,1'b0,1'b0,1'b0,3'd1,2'd2,2'd1,2'd1,16'hFFE6},
    {1'b1,1'b0,1'b1,1'b1,3'd2,2'd0,2'd0,2'd1,16'hFFEA},
    {1'b1,1'b1,1'b0,1'b0,3'd3,2'd1,2'd1,2'd2,16'hFFFE},
    {1'b1,1'b1,1'b0,1'b1,3'd1,2'd1,2'd0,2'd2,16'hFFFE},
    {1'b1,1'b1,1'b1,1'b0,3'd2,2'd0,2'd1,2'd2,16'hFFFA},
    {1'b0,1'b1,1'b0,1'b0,3'd0,2'd1,2'd2,2'd3,16'hFFD4},
    {1'b0,1'b1,1'b0,1'b1,3'd4,2'd1,2'd0,2'd3,16'hFFFC},
    {1'b1,1'b0,1'b0,1'b0,3'd0,2'd2,2'd1,2'd1,16'hFFE4},
    {1'b1,1'b1,1'b1,1'b1,3'd0,2'd0,2'd0,2'd2,16'hFFF4},
    {1'b0,1'b0,1'b0,1'b1,3'd2,2'd2,2'd0,2'd0,16'hFFDA}
  };

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    op_valid = 1'b1;
    op_byte = b;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 emu_hi", {23'd0, emu_hi}, 24'd1);
    chk("R1 emu_lo", {23'd0, emu_lo}, 24'd1);
    chk("R1 mode", {22'd0, mode}, 24'd2);
    chk("R1 done/clear/v/c", {20'd0, xchg_done, idx_clear, v_new, c_new}, 24'd0);

    for (int i = 0; i < N; i++) begin
      logic [28:0] e;
      logic exp_clr;
      e = TBL[i];
      @(negedge clk);
      op_valid = 1'b1; op_byte = 8'h42;
      @(negedge clk);
      op_byte = 8'hFB;
      v_in = e[28]; c_in = e[27]; m_flag = e[26]; x_flag = e[25]; vec_src = e[24:22];
      exp_clr = !m_hi && e[28] && !e[25];
      @(negedge clk);
      op_valid = 1'b0;
      chk("R2 xchg_done", {23'd0, xchg_done}, 24'd1);
      chk("R4 emu flags", {22'd0, emu_hi, emu_lo}, {22'd0, e[28], e[27]});
      chk("R4 returned v/c", {22'd0, v_new, c_new}, {22'd0, m_hi, m_lo});
      chk("R10 idx_clear", {23'd0, idx_clear}, {23'd0, exp_clr});
      chk("R5 mode", {22'd0, mode}, {22'd0, e[17:16]});
      chk("R6 acc_w", {22'd0, acc_w}, {22'd0, e[21:20]});
      chk("R7 idx_w", {22'd0, idx_w}, {22'd0, e[19:18]});
      chk("R8 R9 vec_addr", vec_addr, {8'h00, e[15:0]});
      m_hi = e[28]; m_lo = e[27];
      @(negedge clk);
      chk("R2 done pulse ends", {22'd0, xchg_done, idx_clear}, 24'd0);
    end

    // State now: emu_hi=0 emu_lo=0
    v_in = 1'b1; c_in = 1'b1; x_flag = 1'b0;
    send(8'hFB);
    chk("R3 lone second byte", {21'd0, emu_hi, emu_lo, xchg_done}, 24'd0);
    send(8'h42);
    send(8'hEA);
    send(8'hFB);
    chk("R3 prefix then other", {21'd0, emu_hi, emu_lo, xchg_done}, 24'd0);

    // Doubled prefix with an idle gap still arms
    send(8'h42);
    send(8'h42);
    @(negedge clk);
    op_valid = 1'b1; op_byte = 8'hFB;
    @(negedge clk);
    op_valid = 1'b0;
    chk("R2 doubled prefix", {21'd0, emu_hi, emu_lo, xchg_done}, 24'b111);
    chk("R10 clear on rise", {23'd0, idx_clear}, 24'd1);

    for (int s = 0; s < 8; s++) begin
      vec_src = 3'(s);
      #1;
      if (s == 4) chk("R9 reset vector emu8", vec_addr, 24'h00FFFC);
    end
    vec_src = 3'd6;
    #1;
    chk("R8 code 6 acts as IRQ", vec_addr, 24'h00FFFE);

    rst_n = 1'b0;
    #5;
    chk("R1 async reset", {22'd0, emu_hi, emu_lo}, 24'b11);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule